// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block is the receive front end of a consumer infrared remote-control receiver. It takes the demodulated infrared line, synchronises it to the system clock and samples it at a slow rate derived from a 3 MHz base tick. A selectable divide of 64 or 128 base ticks gives a sample every 21.3 µs or 42.7 µs. The line can be inverted so that the pulse (carrier present) level is always 1. A glitch filter suppresses excursions shorter than a programmed number of samples. The filtered line is then written as a stream of run-length bytes. Each byte carries the level of a run in its top bit and the run's length in samples, minus one, in its low seven bits.

Nothing is emitted while the line is quiet. A packet opens only after the pulse level has held for a programmed activity threshold, and the samples spent reaching that threshold are not part of the first byte. A packet closes with a one-cycle packet-end strobe once the space level has lasted a programmed multiple of 128 samples. A downstream buffer and decoder consume the byte stream. One 32-bit sample configuration word sets every threshold, and three enable inputs gate the whole block.

Top module: `irrx_rle_sampler`

## Requirements
- R1: Sampling, byte output and packet-end output run only while `glb_en` and `rx_en` are both 1 and `cir_mode` equals 2'b11. Otherwise no byte or packet end is produced and all run, filter and packet state is cleared.
- R2: A base tick occurs every `BASE_DIV` clock cycles. A sample is taken every 64 base ticks when `samp_cfg[0]` is 0 and every 128 base ticks when it is 1.
- R3: With `inv_pol` = 1, a low raw input is the pulse level. Byte bit 7 is always the level after inversion: 1 means pulse and 0 means space.
- R4: The filtered level takes a new value only after that value has been sampled on N consecutive samples, where N is `samp_cfg[7:2]` and 0 acts as 1. Shorter excursions are dropped, and the runs on either side of them merge.
- R5: Each byte is {level, run length in samples minus 1}. It is emitted when the run ends, i.e. on the first sample of the opposite level.
- R6: Each time a run reaches 128 samples, a byte {level, 7'h7F} is emitted and counting restarts. At the level change, a byte for the remainder is emitted only if the remainder is nonzero.
- R7: While no packet is open, nothing is emitted. A packet opens after T consecutive pulse samples, where T = (`samp_cfg[22:16]` + 1) × (128 if `samp_cfg[23]` else 1). Those T samples are excluded from the first pulse byte, and a shorter pulse leaves no trace.
- R8: Inside a packet, a space lasting (`samp_cfg[15:8]` + 1) × 128 samples raises `pkt_end` for one cycle, together with the byte 8'h7F that closes that space, and returns the block to waiting. Shorter spaces do not end the packet.
- R9: After reset, `byte_vld`, `pkt_end` and `byte_data` are 0.
- R10: Two consecutive bytes are at least one sample period apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Raw demodulated infrared line, asynchronous |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| cir_mode | input | 2 | Operating mode select; 2'b11 selects run-length sampling |
| inv_pol | input | 1 | Invert the raw line before filtering |
| samp_cfg | input | 32 | Sample configuration: [0] divide select, [7:2] filter, [15:8] idle, [22:16] activity minus one, [23] activity ×128 |
| byte_vld | output | 1 | Run-length byte valid, one cycle |
| byte_data | output | 8 | Run-length byte: [7] level, [6:0] samples minus one |
| pkt_end | output | 1 | Packet-end strobe, one cycle |

## Verification
The bench targets five corner cases:

- A pulse longer than 128 samples. A design that miscounted at the 128 boundary would emit a short or doubled chunk.
- A space of exactly 128 samples. A design that emitted a zero-length remainder would add a stray byte, visible as a wrong byte count.
- A glitch shorter than the filter setting, both inside a pulse and inside a space. A design that did not merge the runs would split one run into three bytes.
- Activity thresholds at one sample and at ×128 scale. A design that folded the threshold samples into the first byte, or opened on a too-short pulse, produces a wrong first byte or an unwanted packet.
- The ×128 divide with an inverted line. A design that got these wrong would report doubled durations or swapped level bits.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

  localparam int CFG_W     = 32;
  localparam int DUR_W     = 7;
  localparam int BYTE_W    = DUR_W + 1;
  localparam int FILT_W    = 6;
  localparam int IDLE_W    = 8;
  localparam int ACT_W     = 7;
  localparam int ACT_SCALE = 128;
  localparam int IDLE_UNIT = 128;

  localparam logic [1:0] MODE_RLE = 2'b11;

  // sample configuration word, most significant field first
  typedef struct packed {
    logic [7:0]        rsvd_hi;   // 31:24
    logic              act_x128;  // 23
    logic [ACT_W-1:0]  act_m1;    // 22:16
    logic [IDLE_W-1:0] idle_n;    // 15:8
    logic [FILT_W-1:0] filt_n;    // 7:2
    logic              rsvd_lo;   // 1
    logic              div_sel;   // 0
  } samp_cfg_t;

  typedef enum logic {
    ENC_WAIT = 1'b0,
    ENC_RUN  = 1'b1
  } enc_state_t;

endpackage

// File: rtl/irrx_tick_gen.sv
module irrx_tick_gen #(
  parameter int BASE_DIV = 1,
  parameter int DIV_LO   = 64,
  parameter int DIV_HI   = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic div_sel,
  output logic s_tick
);
  localparam int SW = $clog2(DIV_HI + 1);

  logic          base_tick;
  logic [SW-1:0] scnt;
  logic [SW-1:0] slim;

  generate
    if (BASE_DIV == 1) begin : g_nopre
      assign base_tick = 1'b1;
    end else begin : g_pre
      localparam int BW = $clog2(BASE_DIV);
      logic [BW-1:0] bcnt;
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          bcnt <= '0;
        end else if (bcnt == BW'(BASE_DIV - 1)) begin
          bcnt <= '0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
      assign base_tick = (bcnt == BW'(BASE_DIV - 1));
    end
  endgenerate

  assign slim = div_sel ? SW'(DIV_HI - 1) : SW'(DIV_LO - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      scnt <= '0;
    end else if (base_tick) begin
      scnt <= (scnt >= slim) ? '0 : scnt + 1'b1;
    end
  end

  assign s_tick = en && base_tick && (scnt >= slim);

endmodule

// File: rtl/irrx_glitch_filt.sv
module irrx_glitch_filt #(
  parameter int FILT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ir_in,
  input  logic              inv_pol,
  input  logic              s_tick,
  input  logic [FILT_W-1:0] filt_n,
  output logic              lvl
);
  localparam int CW = FILT_W + 1;

  logic [1:0]        sync_q;
  logic              pol_in;
  logic [FILT_W-1:0] cnt;
  logic [FILT_W-1:0] need;

  // two-stage synchroniser on the asynchronous line
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], ir_in};
    end
  end

  assign pol_in = sync_q[1] ^ inv_pol;
  assign need   = (filt_n == '0) ? FILT_W'(1) : filt_n;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else if (s_tick) begin
      if (pol_in == lvl) begin
        cnt <= '0;
      end else if (({1'b0, cnt} + CW'(1)) >= {1'b0, need}) begin
        lvl <= pol_in;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/irrx_rle_enc.sv
module irrx_rle_enc
  import irrx_pkg::*;
#(
  parameter int P_DUR_W     = 7,
  parameter int P_ACT_W     = 7,
  parameter int P_ACT_SCALE = 128,
  parameter int P_IDLE_W    = 8,
  parameter int P_IDLE_UNIT = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                s_tick,
  input  logic                lvl,
  input  logic [P_ACT_W-1:0]  act_m1,
  input  logic                act_x128,
  input  logic [P_IDLE_W-1:0] idle_n,
  output logic                byte_vld,
  output logic [P_DUR_W:0]    byte_data,
  output logic                pkt_end
);
  localparam int RUN_MAX = 1 << P_DUR_W;
  localparam int RW      = P_DUR_W + 1;
  localparam int AW      = P_ACT_W + $clog2(P_ACT_SCALE) + 1;
  localparam int IW      = P_IDLE_W + $clog2(P_IDLE_UNIT) + 1;

  enc_state_t         st_q, st_d;
  logic               cur_q, cur_d;
  logic [RW-1:0]      run_q, run_d;
  logic [AW-1:0]      acnt_q, acnt_d, act_thr;
  logic [IW-1:0]      icnt_q, icnt_d, idle_lim;
  logic               emit, end_d;
  logic [P_DUR_W-1:0] emit_dur;

  always_comb begin
    act_thr = AW'(act_m1) + AW'(1);
    if (act_x128) act_thr = act_thr * AW'(P_ACT_SCALE);
    idle_lim = (IW'(idle_n) + IW'(1)) * IW'(P_IDLE_UNIT);
  end

  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    run_d    = run_q;
    acnt_d   = acnt_q;
    icnt_d   = icnt_q;
    emit     = 1'b0;
    emit_dur = '0;
    end_d    = 1'b0;
    if (s_tick) begin
      case (st_q)
        ENC_WAIT: begin
          if (lvl) begin
            if ((acnt_q + AW'(1)) >= act_thr) begin
              st_d   = ENC_RUN;
              cur_d  = 1'b1;
              run_d  = '0;
              icnt_d = '0;
              acnt_d = '0;
            end else begin
              acnt_d = acnt_q + AW'(1);
            end
          end else begin
            acnt_d = '0;
          end
        end
        ENC_RUN: begin
          if (lvl == cur_q) begin
            if ((run_q + RW'(1)) == RW'(RUN_MAX)) begin
              emit     = 1'b1;
              emit_dur = '1;
              run_d    = '0;
            end else begin
              run_d = run_q + RW'(1);
            end
            if (!lvl) begin
              if ((icnt_q + IW'(1)) == idle_lim) begin
                if (!emit) begin
                  emit     = 1'b1;
                  emit_dur = P_DUR_W'(run_q);
                end
                end_d  = 1'b1;
                st_d   = ENC_WAIT;
                run_d  = '0;
                icnt_d = '0;
              end else begin
                icnt_d = icnt_q + IW'(1);
              end
            end
          end else begin
            if (run_q != '0) begin
              emit     = 1'b1;
              emit_dur = P_DUR_W'(run_q - RW'(1));
            end
            cur_d  = lvl;
            run_d  = RW'(1);
            icnt_d = lvl ? IW'(0) : IW'(1);
          end
        end
        default: st_d = ENC_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q      <= ENC_WAIT;
      cur_q     <= 1'b0;
      run_q     <= '0;
      acnt_q    <= '0;
      icnt_q    <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      pkt_end   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_q    <= cur_d;
      run_q    <= run_d;
      acnt_q   <= acnt_d;
      icnt_q   <= icnt_d;
      byte_vld <= emit;
      pkt_end  <= end_d;
      if (emit) byte_data <= {cur_q, emit_dur};
    end
  end

endmodule

// File: rtl/irrx_rle_sampler.sv
module irrx_rle_sampler
  import irrx_pkg::*;
#(
  parameter int BASE_DIV = 1,
  parameter int DIV_LO   = 64,
  parameter int DIV_HI   = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_in,
  input  logic              glb_en,
  input  logic              rx_en,
  input  logic [1:0]        cir_mode,
  input  logic              inv_pol,
  input  logic [CFG_W-1:0]  samp_cfg,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              pkt_end
);
  samp_cfg_t cfg;
  logic      run_en;
  logic      s_tick;
  logic      flt_lvl;
  logic      unused_cfg;

  assign cfg        = samp_cfg_t'(samp_cfg);
  assign run_en     = glb_en && rx_en && (cir_mode == MODE_RLE);
  assign unused_cfg = ^{cfg.rsvd_hi, cfg.rsvd_lo};

  irrx_tick_gen #(
    .BASE_DIV (BASE_DIV),
    .DIV_LO   (DIV_LO),
    .DIV_HI   (DIV_HI)
  ) tick_i (
    .clk     (clk),
    .rst     (rst),
    .en      (run_en),
    .div_sel (cfg.div_sel),
    .s_tick  (s_tick)
  );

  irrx_glitch_filt #(
    .FILT_W (FILT_W)
  ) filt_i (
    .clk     (clk),
    .rst     (rst),
    .en      (run_en),
    .ir_in   (ir_in),
    .inv_pol (inv_pol),
    .s_tick  (s_tick),
    .filt_n  (cfg.filt_n),
    .lvl     (flt_lvl)
  );

  irrx_rle_enc #(
    .P_DUR_W     (DUR_W),
    .P_ACT_W     (ACT_W),
    .P_ACT_SCALE (ACT_SCALE),
    .P_IDLE_W    (IDLE_W),
    .P_IDLE_UNIT (IDLE_UNIT)
  ) enc_i (
    .clk       (clk),
    .rst       (rst),
    .en        (run_en),
    .s_tick    (s_tick),
    .lvl       (flt_lvl),
    .act_m1    (cfg.act_m1),
    .act_x128  (cfg.act_x128),
    .idle_n    (cfg.idle_n),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .pkt_end   (pkt_end)
  );

endmodule

// File: rtl/irrx_rle_sampler_chk.sv
module irrx_rle_sampler_chk (
  input logic       clk,
  input logic       rst,
  input logic       glb_en,
  input logic       rx_en,
  input logic [1:0] cir_mode,
  input logic       byte_vld,
  input logic [7:0] byte_data,
  input logic       pkt_end
);

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    !(glb_en && rx_en && cir_mode == 2'b11) |=> (!byte_vld && !pkt_end));

  assert_end_with_space_byte_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_end |-> (byte_vld && byte_data == 8'h7F));

  assert_end_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> !pkt_end);

  assert_byte_gap_R10: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!byte_vld && !pkt_end && byte_data == 8'h00));

endmodule

bind irrx_rle_sampler irrx_rle_sampler_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .glb_en    (glb_en),
  .rx_en     (rx_en),
  .cir_mode  (cir_mode),
  .byte_vld  (byte_vld),
  .byte_data (byte_data),
  .pkt_end   (pkt_end)
);

// File: tb/irrx_rle_sampler_tb_top.sv
module irrx_rle_sampler_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_raw = 1'b0;
  logic        glb_en = 1'b0;
  logic        rx_en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        inv = 1'b0;
  logic [31:0] cfg = 32'h0;
  logic        byte_vld;
  logic [7:0]  byte_data;
  logic        pkt_end;

  always #4 clk = ~clk;

  irrx_rle_sampler dut_i (
    .clk       (clk),
    .rst       (rst),
    .ir_in     (ir_raw),
    .glb_en    (glb_en),
    .rx_en     (rx_en),
    .cir_mode  (mode),
    .inv_pol   (inv),
    .samp_cfg  (cfg),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .pkt_end   (pkt_end)
  );

  int n_chk = 0;
  int n_bad = 0;
  int sp = 64;
  bit done = 0;

  logic [7:0] got [0:31];
  logic [7:0] expq [$];
  int nb = 0;
  int pe_cnt = 0;
  int pe_at = -1;
  int gap_err = 0;
  int cyc = 0;
  int last_b = -100000;

  always @(posedge clk) cyc <= cyc + 1;

  // capture monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_vld) begin
        if (cyc - last_b < sp) gap_err++;
        last_b = cyc;
        if (nb < 32) got[nb] = byte_data;
        nb++;
      end
      if (pkt_end) begin
        pe_cnt++;
        pe_at = nb;
      end
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit div128, input int filt,
                                         input int idle, input int act_m1,
                                         input bit x128);
    return {8'h00, x128, 7'(act_m1), 8'(idle), 6'(filt), 1'b0, div128};
  endfunction

  task automatic drv(input logic v, input int n);
    ir_raw = v;
    repeat (n * sp) @(negedge clk);
  endtask

  task automatic start(input logic [31:0] c, input logic iv, input logic idle_raw,
                       input int s);
    @(negedge clk);
    glb_en = 1'b0;
    ir_raw = idle_raw;
    inv    = iv;
    cfg    = c;
    sp     = s;
    repeat (4) @(negedge clk);
    nb = 0; pe_cnt = 0; pe_at = -1; gap_err = 0; last_b = -100000;
    glb_en = 1'b1;
    rx_en  = 1'b1;
    mode   = 2'b11;
  endtask

  task automatic cmp_stream(input string req, input int exp_pe_at);
    chk_eq({req, " byte count"}, nb, expq.size());
    foreach (expq[i]) begin
      if (i < nb && i < 32) chk_eq({req, " byte value"}, int'(got[i]), int'(expq[i]));
    end
    chk_eq({req, " packet end count"}, pe_cnt, (exp_pe_at > 0) ? 1 : 0);
    if (exp_pe_at > 0) chk_eq({req, " packet end position"}, pe_at, exp_pe_at);
    chk_eq("R10 byte spacing", gap_err, 0);
  endtask

  // R9: outputs after reset
  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R9 byte_vld after reset", int'(byte_vld), 0);
    chk_eq("R9 pkt_end after reset", int'(pkt_end), 0);
    chk_eq("R9 byte_data after reset", int'(byte_data), 0);
  endtask

  // R5 R7 R8 R2: basic packet at divide 64, threshold one sample
  task automatic t_basic();
    start(mk_cfg(0, 1, 0, 0, 0), 1'b0, 1'b0, 64);
    drv(0, 10); drv(1, 20); drv(0, 10); drv(1, 5); drv(0, 40); drv(1, 8); drv(0, 140);
    expq = '{8'h92, 8'h09, 8'h84, 8'h27, 8'h87, 8'h7F};
    cmp_stream("R5 R2 basic packet", 6);
  endtask

  // R6 R8: long pulse, exact 128 space, idle threshold of 256
  task automatic t_long();
    start(mk_cfg(0, 1, 1, 0, 0), 1'b0, 1'b0, 64);
    drv(1, 301); drv(0, 128); drv(1, 3); drv(0, 268);
    expq = '{8'hFF, 8'hFF, 8'hAB, 8'h7F, 8'h82, 8'h7F, 8'h7F};
    cmp_stream("R6 R8 long runs", 7);
  endtask

  // R4 R7: glitches below the filter setting, threshold of five samples
  task automatic t_glitch();
    start(mk_cfg(0, 8, 0, 4, 0), 1'b0, 1'b0, 64);
    drv(0, 8); drv(1, 5); drv(0, 7);
    drv(1, 20); drv(0, 5); drv(1, 20);
    drv(0, 14); drv(1, 3); drv(0, 13);
    drv(1, 10); drv(0, 150);
    expq = '{8'hA7, 8'h1D, 8'h89, 8'h7F};
    cmp_stream("R4 glitch merge", 4);
  endtask

  // R7: scaled activity threshold of 128 samples
  task automatic t_active();
    start(mk_cfg(0, 1, 0, 0, 1), 1'b0, 1'b0, 64);
    drv(1, 100); drv(0, 20);
    chk_eq("R7 short pulse emits nothing", nb, 0);
    chk_eq("R7 short pulse opens no packet", pe_cnt, 0);
    drv(1, 150); drv(0, 140);
    expq = '{8'h95, 8'h7F};
    cmp_stream("R7 scaled threshold", 2);
  endtask

  // R2 R3: divide 128 with inverted line
  task automatic t_invert();
    start(mk_cfg(1, 1, 0, 0, 0), 1'b1, 1'b1, 128);
    drv(1, 5); drv(0, 12); drv(1, 6); drv(0, 4); drv(1, 140);
    expq = '{8'h8A, 8'h05, 8'h83, 8'h7F};
    cmp_stream("R2 R3 inverted divide 128", 4);
  endtask

  // R1: any missing enable keeps the block silent
  task automatic t_off(input logic g, input logic r, input logic [1:0] m, input string tag);
    start(mk_cfg(0, 1, 0, 0, 0), 1'b0, 1'b0, 64);
    glb_en = g; rx_en = r; mode = m;
    drv(1, 20); drv(0, 20); drv(1, 20); drv(0, 5);
    chk_eq({"R1 no bytes ", tag}, nb, 0);
    chk_eq({"R1 no packet end ", tag}, pe_cnt, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_long();
    t_glitch();
    t_active();
    t_invert();
    t_off(1'b0, 1'b1, 2'b11, "global off");
    t_off(1'b1, 1'b0, 2'b11, "receive off");
    t_off(1'b1, 1'b1, 2'b01, "wrong mode");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule